// File: doc/BRIEF.md
# TMDS Three-Channel Transmit Encoder

This block turns one pixel clock's worth of display payload into three 10-bit TMDS characters per clock, one per lane. Each lane carries 8 bits of pixel data, 4 bits of auxiliary data and two control bits. Lane 0 carries the two sync lines. Lanes 1 and 2 carry a 4-bit control bus. A format select picks plain DVI operation or HDMI operation. In DVI mode the stream holds only pixel characters and control characters, and the video enable chooses between them. In HDMI mode the block also codes auxiliary data periods with TERC4, and it puts a preamble and leading guard bands in front of every period. It also puts trailing guard bands after every auxiliary data period.

So that the inserted characters can come before a period, every input travels through a delay line that is as long as the preamble plus the guard band. When an enable rises at the input, the encoder learns that a period is coming while the control samples in front of it are still in the line. It then overwrites those control samples with the preamble and guard band characters. The serialiser sits downstream and is not part of this block. The block does not decide where auxiliary periods fall. The source supplies both enables.

Top module: `tmds_tx_encoder`

## Requirements
- R1: While `rst_n` is low, and until the delayed stream carries other data, every lane outputs the control character for {D1,D0}=00, which is 1101010100.
- R2: An input sample captured at clock edge k sets the characters output after edge k+PRE_LEN+GB_LEN. The defaults give a latency of 10 edges, and this latency is the same in both formats.
- R3: For a pixel character, stage one keeps bit 0 as it is and forms each higher bit from the previous result with XNOR or XOR. XNOR is used when the byte has more than four ones, or exactly four ones with bit 0 clear; otherwise XOR is used. Bit 8 is 1 for XOR and 0 for XNOR.
- R4: Stage two keeps a signed running disparity per lane. The disparity decides whether bits 7:0 are inverted, and bit 9 shows the inversion, following the standard TMDS balance rule. The disparity is set to zero by every character that is not a pixel character.
- R5: A control character codes {D1,D0} as 00→1101010100, 01→0010101011, 10→0101010100, 11→1010101011. Lane 0 uses {vsync,hsync}, lane 1 uses {ctl[1],ctl[0]} and lane 2 uses {ctl[3],ctl[2]}.
- R6: When `fmt_hdmi`=0, every lane outputs pixel characters while `vid_en` is high and control characters otherwise. `aux_en` and `aux` have no effect on the output in this mode.
- R7: When `fmt_hdmi`=1, the PRE_LEN=8 slots that come before the two leading guard slots of a period are preamble control characters. In these slots lanes 1 and 2 code a forced bus of ctl=4'b0001 before a video period and ctl=4'b0101 before an auxiliary period. Lane 0 keeps coding the sync lines.
- R8: The two slots just before a video period are guard characters: 1011001100 on lanes 0 and 2 and 0100110011 on lane 1. No guard follows a video period.
- R9: During an auxiliary period each lane outputs the TERC4 code of its 4-bit `aux` field, for example 0000→1010011100, 0001→1001100011, 1000→1011001100, 1111→1011000011.
- R10: An auxiliary period has two leading guard slots and two trailing guard slots. In these slots lanes 1 and 2 output 0100110011 and lane 0 outputs the TERC4 code of {1,1,vsync,hsync}.
- R11: Payload beats a trailing guard, a trailing guard beats inserted characters, and inserted characters beat plain control characters. When a later period start overlaps an insertion already in progress, the insertion restarts from its first slot. `vid_en` takes priority over `aux_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fmt_hdmi | input | 1 | 1 = HDMI stream, 0 = DVI stream |
| vid_en | input | 1 | Video period enable |
| aux_en | input | 1 | Auxiliary data period enable |
| hsync | input | 1 | Horizontal sync (lane 0 D0) |
| vsync | input | 1 | Vertical sync (lane 0 D1) |
| ctl | input | 4 | Control bus; bits 1:0 on lane 1, bits 3:2 on lane 2 |
| pix | input | 24 | Pixel bytes; lane n in bits 8n+7:8n |
| aux | input | 12 | Auxiliary nibbles; lane n in bits 4n+3:4n |
| tmds | output | 30 | Coded characters; lane n in bits 10n+9:10n |

## Verification
The hardest case is a single clock in which the trailing guard of one auxiliary period, the preamble of the next period and the payload of an earlier period all claim the same output slot. The same applies when a new period start cuts into an insertion that is still running. The stimulus brings these about with control gaps shorter than the insertion window: gaps of 1, 3 and 4 clocks, an auxiliary period followed at once by video, and both enables raised together. Every character is compared against a model that looks ahead in the recorded stimulus, picks the slot type by the priority order, and computes the disparity and codes arithmetically. Pixel characters are also decoded back to the byte as an independent check.

// File: rtl/tmds_pkg.sv
`timescale 1ns/1ps
package tmds_pkg;
  localparam int NCH  = 3;
  localparam int PIXW = 8;
  localparam int AUXW = 4;
  localparam int SYMW = 10;
  localparam int CTLW = 4;

  typedef enum logic [2:0] {
    CK_CTL = 3'd0,
    CK_VID = 3'd1,
    CK_ISL = 3'd2,
    CK_VGB = 3'd3,
    CK_IGB = 3'd4
  } chr_kind_e;

  localparam logic [SYMW-1:0] GB_VID_A = 10'b1011001100;
  localparam logic [SYMW-1:0] GB_VID_B = 10'b0100110011;
  localparam logic [SYMW-1:0] GB_ISL   = 10'b0100110011;
  localparam logic [CTLW-1:0] PRE_VID_CTL = 4'b0001;
  localparam logic [CTLW-1:0] PRE_ISL_CTL = 4'b0101;

  function automatic logic [SYMW-1:0] ctl_sym(input logic [1:0] c);
    logic [SYMW-1:0] r;
    case (c)
      2'b00:   r = 10'b1101010100;
      2'b01:   r = 10'b0010101011;
      2'b10:   r = 10'b0101010100;
      default: r = 10'b1010101011;
    endcase
    return r;
  endfunction

  function automatic logic [SYMW-1:0] terc4_sym(input logic [3:0] d);
    logic [SYMW-1:0] r;
    case (d)
      4'h0:    r = 10'b1010011100;
      4'h1:    r = 10'b1001100011;
      4'h2:    r = 10'b1011100100;
      4'h3:    r = 10'b1011100010;
      4'h4:    r = 10'b0101110001;
      4'h5:    r = 10'b0100011110;
      4'h6:    r = 10'b0110001110;
      4'h7:    r = 10'b0100111100;
      4'h8:    r = 10'b1011001100;
      4'h9:    r = 10'b0100111001;
      4'hA:    r = 10'b0110011100;
      4'hB:    r = 10'b1011000110;
      4'hC:    r = 10'b1010001110;
      4'hD:    r = 10'b1001110001;
      4'hE:    r = 10'b0101100011;
      default: r = 10'b1011000011;
    endcase
    return r;
  endfunction

  function automatic logic [3:0] ones8(input logic [7:0] v);
    logic [3:0] n;
    n = '0;
    for (int i = 0; i < 8; i++) n = n + {3'b000, v[i]};
    return n;
  endfunction
endpackage

// File: rtl/tmds_period_seq.sv
`timescale 1ns/1ps
module tmds_period_seq
  import tmds_pkg::*;
#(
  parameter int PRE_LEN = 8,
  parameter int GB_LEN  = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   fmt_hdmi,
  input  logic                   vid_en,
  input  logic                   aux_en,
  input  logic                   hsync,
  input  logic                   vsync,
  input  logic [CTLW-1:0]        ctl,
  input  logic [NCH*PIXW-1:0]    pix,
  input  logic [NCH*AUXW-1:0]    aux,
  output chr_kind_e              kind_o,
  output logic [NCH*PIXW-1:0]    pix_o,
  output logic [NCH*AUXW-1:0]    aux_o,
  output logic [2*NCH-1:0]       csel_o
);
  localparam int DLY   = PRE_LEN + GB_LEN;
  localparam int DEPTH = DLY + GB_LEN;
  localparam int SLOTW = $clog2(DLY + 1);

  typedef struct packed {
    logic                fmt;
    logic                ve;
    logic                ae;
    logic                hs;
    logic                vs;
    logic [CTLW-1:0]     cbus;
    logic [NCH*PIXW-1:0] px;
    logic [NCH*AUXW-1:0] ax;
  } smp_t;

  smp_t             line_q [DEPTH];
  smp_t             line_d [DEPTH];
  smp_t             in_s;
  smp_t             head;
  smp_t             cur;
  logic             st_vid, st_isl, start;
  logic             busy_q, busy_d, busy_now;
  logic [SLOTW-1:0] slot_q, slot_d, slot_now;
  logic             isl_q, isl_d, isl_now;
  logic             trail_hit, trail_blk;
  logic             pre_on;
  logic [CTLW-1:0]  ctl_eff;

  // capture: video priority applied at the edge of the block
  always_comb begin
    in_s.fmt  = fmt_hdmi;
    in_s.ve   = vid_en;
    in_s.ae   = aux_en & ~vid_en;
    in_s.hs   = hsync;
    in_s.vs   = vsync;
    in_s.cbus = ctl;
    in_s.px   = pix;
    in_s.ax   = aux;
    line_d[0] = in_s;
    for (int i = 1; i < DEPTH; i++) line_d[i] = line_q[i-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) line_q[i] <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) line_q[i] <= line_d[i];
    end
  end

  assign head = line_q[0];
  assign cur  = line_q[DLY-1];

  // period start seen at the input, DLY samples ahead of the encode point
  always_comb begin
    st_vid   = fmt_hdmi & vid_en & ~head.ve;
    st_isl   = fmt_hdmi & in_s.ae & ~head.ae;
    start    = st_vid | st_isl;
    busy_now = start | busy_q;
    slot_now = start ? '0 : slot_q;
    isl_now  = start ? st_isl : isl_q;
    busy_d   = busy_now && (slot_now != SLOTW'(DLY - 1));
    slot_d   = busy_now ? slot_now + SLOTW'(1) : '0;
    isl_d    = isl_now;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      slot_q <= '0;
      isl_q  <= 1'b0;
    end else begin
      busy_q <= busy_d;
      slot_q <= slot_d;
      isl_q  <= isl_d;
    end
  end

  // trailing guard: an island sample within GB_LEN behind, no video between
  always_comb begin
    trail_hit = 1'b0;
    trail_blk = 1'b0;
    for (int j = 1; j <= GB_LEN; j++) begin
      if (!trail_blk) begin
        if (line_q[DLY-1+j].ae) begin
          trail_hit = 1'b1;
          trail_blk = 1'b1;
        end else if (line_q[DLY-1+j].ve) begin
          trail_blk = 1'b1;
        end
      end
    end
  end

  always_comb begin
    pre_on = 1'b0;
    if (!cur.fmt)           kind_o = cur.ve ? CK_VID : CK_CTL;
    else if (cur.ve)        kind_o = CK_VID;
    else if (cur.ae)        kind_o = CK_ISL;
    else if (trail_hit)     kind_o = CK_IGB;
    else if (busy_now) begin
      if (slot_now < SLOTW'(PRE_LEN)) begin
        kind_o = CK_CTL;
        pre_on = 1'b1;
      end else begin
        kind_o = isl_now ? CK_IGB : CK_VGB;
      end
    end else                kind_o = CK_CTL;
    ctl_eff = pre_on ? (isl_now ? PRE_ISL_CTL : PRE_VID_CTL) : cur.cbus;
    csel_o  = {ctl_eff[3], ctl_eff[2], ctl_eff[1], ctl_eff[0], cur.vs, cur.hs};
    pix_o   = cur.px;
    aux_o   = cur.ax;
  end

  // R7
  slot_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (slot_q < SLOTW'(DLY)));

  // R7
  start_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (busy_q && slot_q == SLOTW'(1)));

  // R10
  island_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (kind_o == CK_ISL && line_q[DLY-2].fmt) |=> (kind_o != CK_CTL));
endmodule

// File: rtl/tmds_chan_enc.sv
`timescale 1ns/1ps
module tmds_chan_enc
  import tmds_pkg::*;
#(
  parameter int CH = 0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  chr_kind_e       kind_i,
  input  logic [PIXW-1:0] pix_i,
  input  logic [AUXW-1:0] aux_i,
  input  logic [1:0]      csel_i,
  output logic [SYMW-1:0] sym_o
);
  localparam logic [SYMW-1:0] VGB_SYM = (CH == 1) ? GB_VID_B : GB_VID_A;

  logic [8:0]        qm;
  logic              use_xnor, chain;
  logic [3:0]        n1_in, n1_qm;
  logic signed [5:0] bal, disp_q, disp_d, vid_disp;
  logic [SYMW-1:0]   vid_sym, igb_sym, sym_d, sym_q;

  generate
    if (CH == 0) begin : g_igb_sync
      assign igb_sym = terc4_sym({2'b11, csel_i});
    end else begin : g_igb_const
      assign igb_sym = GB_ISL;
    end
  endgenerate

  // stage one: transition minimising chain
  always_comb begin
    n1_in    = ones8(pix_i);
    use_xnor = (n1_in > 4'd4) || (n1_in == 4'd4 && !pix_i[0]);
    chain    = pix_i[0];
    qm[0]    = chain;
    for (int i = 1; i < PIXW; i++) begin
      chain = use_xnor ? ~(chain ^ pix_i[i]) : (chain ^ pix_i[i]);
      qm[i] = chain;
    end
    qm[8] = ~use_xnor;
  end

  // stage two: disparity balance
  always_comb begin
    n1_qm = ones8(qm[7:0]);
    bal   = $signed({1'b0, n1_qm, 1'b0}) - 6'sd8;
    if (disp_q == 6'sd0 || bal == 6'sd0) begin
      vid_sym  = {~qm[8], qm[8], qm[8] ? qm[7:0] : ~qm[7:0]};
      vid_disp = qm[8] ? disp_q + bal : disp_q - bal;
    end else if ((disp_q > 6'sd0 && bal > 6'sd0) || (disp_q < 6'sd0 && bal < 6'sd0)) begin
      vid_sym  = {1'b1, qm[8], ~qm[7:0]};
      vid_disp = disp_q + (qm[8] ? 6'sd2 : 6'sd0) - bal;
    end else begin
      vid_sym  = {1'b0, qm[8], qm[7:0]};
      vid_disp = disp_q - (qm[8] ? 6'sd0 : 6'sd2) + bal;
    end
  end

  always_comb begin
    disp_d = '0;
    case (kind_i)
      CK_VID: begin
        sym_d  = vid_sym;
        disp_d = vid_disp;
      end
      CK_ISL:  sym_d = terc4_sym(aux_i);
      CK_IGB:  sym_d = igb_sym;
      CK_VGB:  sym_d = VGB_SYM;
      default: sym_d = ctl_sym(csel_i);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sym_q  <= ctl_sym(2'b00);
      disp_q <= '0;
    end else begin
      sym_q  <= sym_d;
      disp_q <= disp_d;
    end
  end

  assign sym_o = sym_q;

  // R4
  disp_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (kind_i != CK_VID) |=> (disp_q == 6'sd0));

  // R4
  disp_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
    disp_q[0] == 1'b0);
endmodule

// File: rtl/tmds_tx_encoder.sv
`timescale 1ns/1ps
module tmds_tx_encoder
  import tmds_pkg::*;
#(
  parameter int PRE_LEN = 8,
  parameter int GB_LEN  = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 fmt_hdmi,
  input  logic                 vid_en,
  input  logic                 aux_en,
  input  logic                 hsync,
  input  logic                 vsync,
  input  logic [CTLW-1:0]      ctl,
  input  logic [NCH*PIXW-1:0]  pix,
  input  logic [NCH*AUXW-1:0]  aux,
  output logic [NCH*SYMW-1:0]  tmds
);
  chr_kind_e             kind_s;
  logic [NCH*PIXW-1:0]   pix_s;
  logic [NCH*AUXW-1:0]   aux_s;
  logic [2*NCH-1:0]      csel_s;

  tmds_period_seq #(.PRE_LEN(PRE_LEN), .GB_LEN(GB_LEN)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .fmt_hdmi (fmt_hdmi),
    .vid_en   (vid_en),
    .aux_en   (aux_en),
    .hsync    (hsync),
    .vsync    (vsync),
    .ctl      (ctl),
    .pix      (pix),
    .aux      (aux),
    .kind_o   (kind_s),
    .pix_o    (pix_s),
    .aux_o    (aux_s),
    .csel_o   (csel_s)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_lane
    tmds_chan_enc #(.CH(c)) u_enc (
      .clk    (clk),
      .rst_n  (rst_n),
      .kind_i (kind_s),
      .pix_i  (pix_s[c*PIXW +: PIXW]),
      .aux_i  (aux_s[c*AUXW +: AUXW]),
      .csel_i (csel_s[c*2 +: 2]),
      .sym_o  (tmds[c*SYMW +: SYMW])
    );
  end

  // R6
  dvi_no_insert_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (kind_s == CK_VGB || kind_s == CK_IGB || kind_s == CK_ISL) |-> u_seq.cur.fmt);
endmodule

// File: tb/tb_tmds_tx_encoder.sv
`timescale 1ns/1ps
module tb_tmds_tx_encoder;
  localparam int PRE  = 8;
  localparam int GB   = 2;
  localparam int DLY  = PRE + GB;
  localparam int NMAX = 1400;

  logic        clk, rst_n, fmt_hdmi, vid_en, aux_en, hsync, vsync;
  logic [3:0]  ctl;
  logic [23:0] pix;
  logic [11:0] aux;
  logic [29:0] tmds;

  tmds_tx_encoder #(.PRE_LEN(PRE), .GB_LEN(GB)) dut (
    .clk(clk), .rst_n(rst_n), .fmt_hdmi(fmt_hdmi), .vid_en(vid_en),
    .aux_en(aux_en), .hsync(hsync), .vsync(vsync), .ctl(ctl),
    .pix(pix), .aux(aux), .tmds(tmds)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int nchk = 0;
  int nfail = 0;
  bit done = 0;

  logic        s_fmt [NMAX];
  logic        s_ve  [NMAX];
  logic        s_ae  [NMAX];
  logic [3:0]  s_ctl [NMAX];
  logic [23:0] s_pix [NMAX];
  logic [11:0] s_aux [NMAX];
  int nsmp = 0;
  int disp [3];

  localparam logic [9:0] T4 [16] = '{
    10'b1010011100, 10'b1001100011, 10'b1011100100, 10'b1011100010,
    10'b0101110001, 10'b0100011110, 10'b0110001110, 10'b0100111100,
    10'b1011001100, 10'b0100111001, 10'b0110011100, 10'b1011000110,
    10'b1010001110, 10'b1001110001, 10'b0101100011, 10'b1011000011};

  // typ: 0 control, 1 video, 2 island, 3 both enables
  task automatic add_seg(input logic f, input int typ, input int len);
    for (int i = 0; i < len; i++) begin
      int k = nsmp;
      s_fmt[k] = f;
      s_ve[k]  = (typ == 1 || typ == 3);
      s_ae[k]  = (typ == 2 || typ == 3);
      s_ctl[k] = 4'(k / 5);
      s_pix[k] = {8'(k * 37 + 11), 8'(~k), 8'(k)};
      s_aux[k] = {4'(k * 3), 4'(k >> 1), 4'(k)};
      nsmp++;
    end
  endtask

  function automatic logic g_fmt(int p); return (p < 0 || p >= nsmp) ? 1'b0 : s_fmt[p]; endfunction
  function automatic logic g_ve(int p);  return (p < 0 || p >= nsmp) ? 1'b0 : s_ve[p];  endfunction
  function automatic logic g_ae(int p);  return (p < 0 || p >= nsmp) ? 1'b0 : (s_ae[p] & ~s_ve[p]); endfunction
  function automatic logic [3:0] g_ctl(int p); return (p < 0 || p >= nsmp) ? 4'd0 : s_ctl[p]; endfunction
  function automatic logic [23:0] g_pix(int p); return (p < 0 || p >= nsmp) ? 24'd0 : s_pix[p]; endfunction
  function automatic logic [11:0] g_aux(int p); return (p < 0 || p >= nsmp) ? 12'd0 : s_aux[p]; endfunction
  function automatic logic g_hs(int p); return (p < 0 || p >= nsmp) ? 1'b0 : s_pix[p][3]; endfunction
  function automatic logic g_vs(int p); return (p < 0 || p >= nsmp) ? 1'b0 : s_pix[p][6]; endfunction

  // R11: priority payload > trailing guard > latest insertion > control
  function automatic int exp_kind(int p, output bit pre, output bit isl);
    pre = 0;
    isl = 0;
    if (!g_fmt(p)) return g_ve(p) ? 1 : 0;
    if (g_ve(p)) return 1;
    if (g_ae(p)) return 2;
    for (int j = 1; j <= GB; j++) begin
      if (g_ae(p - j)) return 4;
      if (g_ve(p - j)) break;
    end
    for (int t = p + DLY; t > p; t--) begin
      if (g_fmt(t) && ((g_ve(t) && !g_ve(t-1)) || (g_ae(t) && !g_ae(t-1)))) begin
        isl = !g_ve(t);
        if (p - t + DLY < PRE) begin
          pre = 1;
          return 0;
        end
        return isl ? 4 : 3;
      end
    end
    return 0;
  endfunction

  function automatic logic [9:0] b_ctl(logic [1:0] c);
    case (c)
      2'b00:   return 10'b1101010100;
      2'b01:   return 10'b0010101011;
      2'b10:   return 10'b0101010100;
      default: return 10'b1010101011;
    endcase
  endfunction

  function automatic logic [9:0] b_video(int ch, logic [7:0] d);
    int n = 0;
    int c1 = 0;
    int c0;
    bit xn;
    logic [8:0] m;
    logic [7:0] low;
    logic q9;
    for (int i = 0; i < 8; i++) n += int'(d[i]);
    xn = (n > 4) || (n == 4 && d[0] == 1'b0);
    m[0] = d[0];
    for (int i = 1; i < 8; i++) m[i] = xn ? (m[i-1] ~^ d[i]) : (m[i-1] ^ d[i]);
    m[8] = !xn;
    for (int i = 0; i < 8; i++) c1 += int'(m[i]);
    c0 = 8 - c1;
    if (disp[ch] == 0 || c1 == c0) begin
      q9 = !m[8];
      low = m[8] ? m[7:0] : ~m[7:0];
      disp[ch] += m[8] ? (c1 - c0) : (c0 - c1);
    end else if ((disp[ch] > 0 && c1 > c0) || (disp[ch] < 0 && c0 > c1)) begin
      q9 = 1'b1;
      low = ~m[7:0];
      disp[ch] += 2 * int'(m[8]) + c0 - c1;
    end else begin
      q9 = 1'b0;
      low = m[7:0];
      disp[ch] += -2 * (1 - int'(m[8])) + c1 - c0;
    end
    return {q9, m[8], low};
  endfunction

  function automatic logic [7:0] b_decode(logic [9:0] q);
    logic [7:0] v, r;
    v = q[9] ? ~q[7:0] : q[7:0];
    r[0] = v[0];
    for (int i = 1; i < 8; i++) r[i] = q[8] ? (v[i] ^ v[i-1]) : ~(v[i] ^ v[i-1]);
    return r;
  endfunction

  task automatic check_sample(int p);
    bit pre, isl;
    int k;
    logic [3:0] ce;
    logic [1:0] c2;
    logic [9:0] e, got;
    string req;
    k = exp_kind(p, pre, isl);
    ce = pre ? (isl ? 4'b0101 : 4'b0001) : g_ctl(p);
    for (int ch = 0; ch < 3; ch++) begin
      c2 = (ch == 0) ? {g_vs(p), g_hs(p)} : (ch == 1) ? ce[1:0] : ce[3:2];
      got = tmds[ch*10 +: 10];
      case (k)
        1: begin e = b_video(ch, g_pix(p)[ch*8 +: 8]); req = "R3 R4"; end
        2: begin e = T4[g_aux(p)[ch*4 +: 4]]; req = "R9"; disp[ch] = 0; end
        3: begin e = (ch == 1) ? 10'b0100110011 : 10'b1011001100; req = "R8"; disp[ch] = 0; end
        4: begin e = (ch == 0) ? T4[{2'b11, c2}] : 10'b0100110011; req = "R10"; disp[ch] = 0; end
        default: begin
          e = b_ctl(c2);
          req = pre ? "R7" : (g_fmt(p) ? "R5" : "R6");
          disp[ch] = 0;
        end
      endcase
      nchk++;
      if (got !== e) begin
        nfail++;
        $display("FAIL %s (R2 timing) sample %0d lane %0d: got %b expected %b", req, p, ch, got, e);
      end
      if (k == 1) begin
        // R3: decoding the character recovers the byte
        nchk++;
        if (b_decode(got) !== g_pix(p)[ch*8 +: 8]) begin
          nfail++;
          $display("FAIL R3 decode sample %0d lane %0d: got %h expected %h",
                   p, ch, b_decode(got), g_pix(p)[ch*8 +: 8]);
        end
      end
    end
  endtask

  task automatic drive(int c);
    fmt_hdmi = g_fmt(c);
    vid_en   = g_ve(c);
    aux_en   = (c < 0 || c >= nsmp) ? 1'b0 : s_ae[c];
    hsync    = g_hs(c);
    vsync    = g_vs(c);
    ctl      = g_ctl(c);
    pix      = g_pix(c);
    aux      = g_aux(c);
  endtask

  initial begin
    for (int ch = 0; ch < 3; ch++) disp[ch] = 0;
    // DVI part (R6: island request and aux data have no effect)
    add_seg(0, 0, 30);
    add_seg(0, 1, 300);
    add_seg(0, 0, 20);
    add_seg(0, 2, 20);
    add_seg(0, 0, 15);
    add_seg(0, 1, 40);
    add_seg(0, 0, 30);
    // HDMI part
    add_seg(1, 0, 20);
    add_seg(1, 1, 280);
    add_seg(1, 0, 20);
    add_seg(1, 2, 32);
    add_seg(1, 0, 20);
    add_seg(1, 1, 6);
    add_seg(1, 0, 4);   // R11 short gap: insertion meets video payload
    add_seg(1, 2, 8);
    add_seg(1, 0, 1);   // R11 trailing guard against next preamble
    add_seg(1, 1, 10);
    add_seg(1, 0, 12);
    add_seg(1, 2, 5);
    add_seg(1, 1, 5);   // R11 island straight into video
    add_seg(1, 0, 3);   // R11 restart of a running insertion
    add_seg(1, 2, 4);
    add_seg(1, 0, 14);
    add_seg(1, 3, 6);   // R11 both enables: video wins
    add_seg(1, 0, 30);

    rst_n = 1'b0;
    drive(-1);
    repeat (4) begin
      @(negedge clk);
      // R1
      nchk++;
      if (tmds !== {3{10'b1101010100}}) begin
        nfail++;
        $display("FAIL R1 reset: got %b expected %b", tmds, {3{10'b1101010100}});
      end
    end
    rst_n = 1'b1;
    for (int c = 0; c < nsmp + DLY + 2; c++) begin
      drive(c);
      @(negedge clk);
      if (c - DLY >= 0) check_sample(c - DLY);
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog: got hung run expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end
endmodule